// File: doc/BRIEF.md
# Staged Eight-Channel Output Converter Register Bank

This block keeps the settings of eight analog output channels. A host writes them through a single-cycle register write port and reads them back through a registered read port. Each channel has four settings: a 16-bit output code, a 2-bit range select, a signed fine-gain trim and a signed fractional offset trim. These appear as parallel per-channel outputs that the converter interface logic consumes.

Output codes are staged. A host write to a channel's code only changes a holding register. The value on the output bus moves only when the host writes the control register with its update bit set. That update copies all eight holding values onto the outputs on one clock edge, so every converter sees a coherent new set of codes. The control register also has a wipe bit, which sets every holding code to the bottom of the scale. Trim and range writes act on their outputs directly.

Address map: a channel register sits at address `ch*4 + field`, where field 0 is the code, 1 the range, 2 the fine gain and 3 the offset. The control register sits at address `NUM_CH*4` (0x20 by default). In the control register, bit 0 is the update bit and bit 1 is the wipe bit.

Top module: `dac_shadow_bank`

## Requirements
- R1: After reset every holding code and every output code is 0x8000 (offset-binary mid-scale, zero volts). Range, fine-gain and offset outputs are 0, which means unity gain and no offset correction.
- R2: A write to field 0 of a channel stores the 16-bit offset-binary code (0x0000 negative full scale, 0xFFFF positive full scale) in its holding register. Reading that field returns the last code written, not the output code.
- R3: A code write leaves every output code unchanged. A control write with bit 0 set copies all eight holding codes to the outputs on that same clock edge.
- R4: The control register's update and wipe bits act only on the write and always read back as 0x0000.
- R5: A control write with bit 1 set sets all eight holding codes to 0x0000. It leaves the output codes unchanged until the next update.
- R6: A control write with both bits set applies the wipe first, so every output code becomes 0x0000.
- R7: Field 1 holds a 2-bit range code: 0 selects ±10 V, 1 selects ±10.2564 V and 2 selects ±10.5263 V. The code appears on the channel's range output and reads back in bits [1:0].
- R8: Range code 3 is stored and reads back as 3, but the range output shows 0 (±10 V).
- R9: Field 2 holds a 6-bit two's-complement fine gain (−32 to +31 LSB). It appears on the fine output and reads back in bits [5:0], with the upper bits zero.
- R10: Field 3 holds an 8-bit two's-complement offset in 1/8-LSB steps (−16 to +15.875 LSB). It appears on the offset output and reads back in bits [7:0], with the upper bits zero.
- R11: Read data is registered: `rd_data` shows the register selected by `rd_addr` at the previous clock edge. Addresses above the control register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 6 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 6 | Read address |
| rd_data | output | 16 | Registered read data |
| out_code | output | 128 | Output codes, channel c at [c*16 +: 16] |
| out_range | output | 16 | Range selects, channel c at [c*2 +: 2] |
| out_fine | output | 48 | Fine-gain trims, channel c at [c*6 +: 6] |
| out_offset | output | 64 | Offset trims, channel c at [c*8 +: 8] |

## Verification
The hardest case to reach is a holding register that differs from its output. The bench creates it on purpose: it writes distinct codes and then reads them back before any update, so a readback served from the output register is caught. It then applies a wipe without an update and checks that the outputs still show the old codes while the readback shows zero. The combined wipe-and-update write is issued only after the holding registers have been reloaded with non-zero codes, so an update taken before the wipe is visible.

// File: rtl/dacb_pkg.sv
package dacb_pkg;
  typedef enum logic [1:0] {
    FLD_CODE   = 2'd0,
    FLD_RANGE  = 2'd1,
    FLD_FINE   = 2'd2,
    FLD_OFFSET = 2'd3
  } field_e;

  localparam int CTRL_UPDATE_BIT = 0;
  localparam int CTRL_WIPE_BIT   = 1;
  localparam logic [1:0] RANGE_UNUSED = 2'd3;
  localparam logic [1:0] RANGE_DEFAULT = 2'd0;
endpackage

// File: rtl/dacb_decode.sv
module dacb_decode
  import dacb_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [NUM_CH-1:0] code_we,
  output logic [NUM_CH-1:0] range_we,
  output logic [NUM_CH-1:0] fine_we,
  output logic [NUM_CH-1:0] ofs_we,
  output logic              update,
  output logic              wipe
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(NUM_CH * 4);

  logic            in_ch;
  logic [CH_W-1:0] ch;
  logic [1:0]      fld;

  assign in_ch = wr_addr < CTRL_A;
  assign ch    = wr_addr[CH_W+1:2];
  assign fld   = wr_addr[1:0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit         = wr_en && in_ch && (ch == CH_W'(c));
    assign code_we[c]  = hit && (fld == FLD_CODE);
    assign range_we[c] = hit && (fld == FLD_RANGE);
    assign fine_we[c]  = hit && (fld == FLD_FINE);
    assign ofs_we[c]   = hit && (fld == FLD_OFFSET);
  end

  assign update = wr_en && (wr_addr == CTRL_A) && wr_data[CTRL_UPDATE_BIT];
  assign wipe   = wr_en && (wr_addr == CTRL_A) && wr_data[CTRL_WIPE_BIT];
endmodule

// File: rtl/dacb_channel.sv
module dacb_channel
  import dacb_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int RANGE_W = 2,
  parameter int FINE_W  = 6,
  parameter int OFS_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               code_we,
  input  logic               range_we,
  input  logic               fine_we,
  input  logic               ofs_we,
  input  logic               update,
  input  logic               wipe,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [DATA_W-1:0]  hold,
  output logic [DATA_W-1:0]  out_code,
  output logic [RANGE_W-1:0] range_raw,
  output logic [RANGE_W-1:0] out_range,
  output logic [FINE_W-1:0]  out_fine,
  output logic [OFS_W-1:0]   out_ofs
);
  localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};

  logic [RANGE_W-1:0] range_in;
  assign range_in = wr_data[RANGE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      hold <= MID;
    end else if (wipe) begin
      hold <= '0;
    end else if (code_we) begin
      hold <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_code <= MID;
    end else if (update) begin
      out_code <= wipe ? '0 : hold;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      range_raw <= '0;
      out_range <= '0;
      out_fine  <= '0;
      out_ofs   <= '0;
    end else begin
      if (range_we) begin
        range_raw <= range_in;
        out_range <= (range_in == RANGE_W'(RANGE_UNUSED)) ? RANGE_W'(RANGE_DEFAULT) : range_in;
      end
      if (fine_we) out_fine <= wr_data[FINE_W-1:0];
      if (ofs_we)  out_ofs  <= wr_data[OFS_W-1:0];
    end
  end

  AST_HOLD_OUT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !update |=> $stable(out_code)); // R3
  AST_UPDATE_COPIES: assert property (@(posedge clk) disable iff (rst)
    (update && !wipe) |=> (out_code == $past(hold))); // R3
  AST_WIPE_FIRST: assert property (@(posedge clk) disable iff (rst)
    (update && wipe) |=> (out_code == '0)); // R6
  AST_WIPE_HOLD: assert property (@(posedge clk) disable iff (rst)
    wipe |=> (hold == '0)); // R5
  AST_RANGE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    out_range != RANGE_W'(RANGE_UNUSED)); // R8
endmodule

// File: rtl/dacb_readmux.sv
module dacb_readmux
  import dacb_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 16,
  parameter int RANGE_W = 2,
  parameter int FINE_W  = 6,
  parameter int OFS_W   = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         rd_addr,
  input  logic [NUM_CH*DATA_W-1:0]  hold_bus,
  input  logic [NUM_CH*RANGE_W-1:0] range_bus,
  input  logic [NUM_CH*FINE_W-1:0]  fine_bus,
  input  logic [NUM_CH*OFS_W-1:0]   ofs_bus,
  output logic [DATA_W-1:0]         rd_data
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(NUM_CH * 4);

  logic [CH_W-1:0]   ch;
  logic [DATA_W-1:0] sel;

  assign ch = rd_addr[CH_W+1:2];

  always_comb begin
    sel = '0;
    if (rd_addr < CTRL_A) begin
      case (rd_addr[1:0])
        FLD_CODE:   sel = hold_bus[ch*DATA_W +: DATA_W];
        FLD_RANGE:  sel = DATA_W'(range_bus[ch*RANGE_W +: RANGE_W]);
        FLD_FINE:   sel = DATA_W'(fine_bus[ch*FINE_W +: FINE_W]);
        default:    sel = DATA_W'(ofs_bus[ch*OFS_W +: OFS_W]);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= sel;
  end

  AST_CTRL_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_addr >= CTRL_A) |=> (rd_data == '0)); // R4
endmodule

// File: rtl/dac_shadow_bank.sv
module dac_shadow_bank
  import dacb_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 16,
  parameter int RANGE_W = 2,
  parameter int FINE_W  = 6,
  parameter int OFS_W   = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [DATA_W-1:0]         rd_data,
  output logic [NUM_CH*DATA_W-1:0]  out_code,
  output logic [NUM_CH*RANGE_W-1:0] out_range,
  output logic [NUM_CH*FINE_W-1:0]  out_fine,
  output logic [NUM_CH*OFS_W-1:0]   out_offset
);
  logic [NUM_CH-1:0] code_we, range_we, fine_we, ofs_we;
  logic              update, wipe;
  logic [NUM_CH*DATA_W-1:0]  hold_bus;
  logic [NUM_CH*RANGE_W-1:0] range_raw_bus;

  dacb_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .code_we(code_we), .range_we(range_we), .fine_we(fine_we), .ofs_we(ofs_we),
    .update(update), .wipe(wipe)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    dacb_channel #(.DATA_W(DATA_W), .RANGE_W(RANGE_W), .FINE_W(FINE_W), .OFS_W(OFS_W)) u_ch (
      .clk(clk), .rst(rst),
      .code_we(code_we[c]), .range_we(range_we[c]), .fine_we(fine_we[c]), .ofs_we(ofs_we[c]),
      .update(update), .wipe(wipe), .wr_data(wr_data),
      .hold(hold_bus[c*DATA_W +: DATA_W]),
      .out_code(out_code[c*DATA_W +: DATA_W]),
      .range_raw(range_raw_bus[c*RANGE_W +: RANGE_W]),
      .out_range(out_range[c*RANGE_W +: RANGE_W]),
      .out_fine(out_fine[c*FINE_W +: FINE_W]),
      .out_ofs(out_offset[c*OFS_W +: OFS_W])
    );
  end

  dacb_readmux #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                 .RANGE_W(RANGE_W), .FINE_W(FINE_W), .OFS_W(OFS_W)) u_rd (
    .clk(clk), .rst(rst), .rd_addr(rd_addr),
    .hold_bus(hold_bus), .range_bus(range_raw_bus), .fine_bus(out_fine), .ofs_bus(out_offset),
    .rd_data(rd_data)
  );
endmodule

// File: tb/tb_dac_shadow_bank.sv
module tb_dac_shadow_bank;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [5:0]   wr_addr = '0;
  logic [15:0]  wr_data = '0;
  logic [5:0]   rd_addr = '0;
  logic [15:0]  rd_data;
  logic [127:0] out_code;
  logic [15:0]  out_range;
  logic [47:0]  out_fine;
  logic [63:0]  out_offset;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] exp_out [N];

  always #2.5 clk = ~clk;

  dac_shadow_bank dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .out_code(out_code), .out_range(out_range),
    .out_fine(out_fine), .out_offset(out_offset)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic check_outs(input string req);
    for (int c = 0; c < N; c++) check(req, 32'(out_code[c*16 +: 16]), 32'(exp_out[c]));
  endtask

  task automatic t_reset;
    logic [15:0] d;
    for (int c = 0; c < N; c++) exp_out[c] = 16'h8000;
    check_outs("R1 output code after reset");
    check("R1 range", 32'(out_range), 32'h0);
    check("R1 fine", 32'(out_fine), 32'h0);
    check("R1 offset", 32'(out_offset), 32'h0);
    rd(6'd0, d);
    check("R1 holding readback", 32'(d), 32'h8000);
  endtask

  task automatic t_staged;
    logic [15:0] d;
    logic [15:0] v [N];
    for (int c = 0; c < N; c++) begin
      v[c] = (c == 0) ? 16'h0000 : (c == 7) ? 16'hFFFF : 16'(16'h1234 * c);
      wr(6'(c*4), v[c]);
    end
    check_outs("R3 code write does not move output");
    for (int c = 0; c < N; c++) begin
      rd(6'(c*4), d);
      check("R2 readback holds last write", 32'(d), 32'(v[c]));
    end
    wr(6'h20, 16'h0001);
    for (int c = 0; c < N; c++) exp_out[c] = v[c];
    check_outs("R3 update copies all channels");
  endtask

  task automatic t_ctrl_read;
    logic [15:0] d;
    wr(6'h20, 16'h0001);
    rd(6'h20, d);
    check("R4 control reads zero", 32'(d), 32'h0);
    rd(6'h3F, d);
    check("R11 unmapped reads zero", 32'(d), 32'h0);
  endtask

  task automatic t_wipe;
    logic [15:0] d;
    wr(6'h20, 16'h0002);
    check_outs("R5 wipe leaves outputs");
    rd(6'd12, d);
    check("R5 wipe zeroes holding", 32'(d), 32'h0);
    wr(6'h20, 16'h0001);
    for (int c = 0; c < N; c++) exp_out[c] = 16'h0000;
    check_outs("R5 update after wipe");
  endtask

  task automatic t_wipe_update;
    for (int c = 0; c < N; c++) wr(6'(c*4), 16'hA5A5);
    wr(6'h20, 16'h0001);
    for (int c = 0; c < N; c++) exp_out[c] = 16'hA5A5;
    check_outs("R3 reload before combined write");
    wr(6'h20, 16'h0003);
    for (int c = 0; c < N; c++) exp_out[c] = 16'h0000;
    check_outs("R6 wipe applied before update");
  endtask

  task automatic t_range;
    logic [15:0] d;
    for (int c = 0; c < 4; c++) wr(6'(c*4 + 1), 16'(c));
    for (int c = 0; c < 3; c++)
      check("R7 range output", 32'(out_range[c*2 +: 2]), 32'(c));
    check("R8 unused code shows default", 32'(out_range[6 +: 2]), 32'h0);
    rd(6'd13, d);
    check("R8 unused code reads back", 32'(d), 32'h3);
    rd(6'd9, d);
    check("R7 range readback", 32'(d), 32'h2);
  endtask

  task automatic t_fine;
    logic [15:0] d;
    wr(6'd10, 16'hFFE0);
    wr(6'd22, 16'h001F);
    check("R9 fine -32 output", 32'(out_fine[2*6 +: 6]), 32'h20);
    check("R9 fine +31 output", 32'(out_fine[5*6 +: 6]), 32'h1F);
    rd(6'd10, d);
    check("R9 fine readback", 32'(d), 32'h0020);
  endtask

  task automatic t_offset;
    logic [15:0] d;
    wr(6'd15, 16'hFF80);
    wr(6'd31, 16'h007F);
    check("R10 offset -16 output", 32'(out_offset[3*8 +: 8]), 32'h80);
    check("R10 offset max output", 32'(out_offset[7*8 +: 8]), 32'h7F);
    rd(6'd15, d);
    check("R10 offset readback", 32'(d), 32'h0080);
    check_outs("R3 trim writes leave codes");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_staged();
    t_ctrl_read();
    t_wipe();
    t_wipe_update();
    t_range();
    t_fine();
    t_offset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule